// File: doc/BRIEF.md
# Interrupt acceptance and vectoring unit

This block sits beside the instruction sequencer of an 8-bit processor core and decides whether an interrupt is taken. It holds the two interrupt enable flip-flops, the two-bit maskable response mode and the interrupt vector register. It watches a level-sensitive maskable request and a non-maskable request line. When a request is taken, it answers with a one-cycle response. The response says whether the core must push its program counter, gives the new program counter value and gives the cycle cost of the response.

In the opcode-injection mode the byte on the data bus is handed back to the core to execute as the next opcode. No jump target is produced in that mode. The core also sends single-cycle control pulses to this block: enable interrupts, disable interrupts, return from a non-maskable handler, set the response mode from an opcode's 3-bit y field, and load the vector register. The second enable flip-flop is brought out so that the core can read it during a register transfer. Pushing the program counter and fetching the injected opcode are the core's work.

All state updates and the registered response happen on the same rising edge. The response is therefore visible in the cycle after the request is sampled, and it lasts one cycle.

Top module: `int_ctrl_unit`

## Requirements
- R1: A maskable request (`irq_req_i`=1) is taken only while the first enable flip-flop (`iff1_o`) is 1. A cycle with no taken request gives `take_o`=0, `push_pc_o`=0, `exec_opcode_o`=0 and `cycles_o`=0.
- R2: The non-maskable line is edge-detected. A 0-to-1 change is taken whatever the enable flip-flops hold. Holding the line high gives only one acceptance.
- R3: A taken non-maskable request gives `take_nmi_o`=1, `push_pc_o`=1, `target_o`=0x0066 and `cycles_o`=13. It clears `iff1_o` and leaves `iff2_o` unchanged.
- R4: A taken maskable request clears both `iff1_o` and `iff2_o`.
- R5: In mode 1 (`mode_o`=1) a taken maskable request gives `push_pc_o`=1, `target_o`=0x0038 and `cycles_o`=13.
- R6: In mode 2 (`mode_o`=2) a taken maskable request gives `push_pc_o`=1, `cycles_o`=19 and `target_o` = {vector register, `data_i`}.
- R7: In mode 0 (`mode_o`=0) a taken maskable request gives `exec_opcode_o`=1 and `opcode_o`=`data_i`, with `push_pc_o`=0, `target_o`=0 and `cycles_o`=0.
- R8: When a non-maskable edge and an enabled maskable request arrive in the same cycle, only the non-maskable request is taken.
- R9: `ei_i` sets both flip-flops, `di_i` clears both, and `retn_i` copies `iff2_o` into `iff1_o`.
- R10: `mode_set_i` loads the mode from `mode_y_i`. y values 0, 1, 4 and 5 give mode 0, y values 2 and 6 give mode 1, and y values 3 and 7 give mode 2.
- R11: Reset clears both flip-flops, sets the mode to 0 and sets the vector register to 0xFF. `vec_wr_i` loads `vec_data_i` into the vector register.
- R12: In one cycle, an acceptance overrides every control pulse. `di_i` overrides `ei_i`, and `ei_i` overrides `retn_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 1 | Maskable request, level |
| nmi_req_i | input | 1 | Non-maskable request, edge-detected |
| data_i | input | 8 | Data-bus byte: low vector byte or injected opcode |
| ei_i | input | 1 | Enable-interrupts pulse |
| di_i | input | 1 | Disable-interrupts pulse |
| retn_i | input | 1 | Return-from-non-maskable pulse |
| mode_set_i | input | 1 | Mode-set pulse |
| mode_y_i | input | 3 | y field of the mode-set opcode |
| vec_wr_i | input | 1 | Vector register load strobe |
| vec_data_i | input | 8 | Vector register load value |
| take_o | output | 1 | A request was taken (one cycle) |
| take_nmi_o | output | 1 | The taken request was non-maskable |
| push_pc_o | output | 1 | Core must push the program counter |
| exec_opcode_o | output | 1 | Core must execute `opcode_o` |
| opcode_o | output | 8 | Injected opcode (mode 0) |
| target_o | output | 16 | New program counter |
| cycles_o | output | 5 | Cycle cost of the response |
| iff1_o | output | 1 | First enable flip-flop |
| iff2_o | output | 1 | Second enable flip-flop |
| mode_o | output | 2 | Current maskable response mode |

## Verification
The bench builds the block with its default parameters. These give an 8-bit data bus, a 16-bit target and a 5-bit cycle field, so the 19-cycle cost of the vectored mode and the full 0xFF reset vector both appear on the ports. With these values, a vectored response taken before any vector load shows 0xFFxx. One taken after a load shows the loaded high byte. All eight y codes are walked through a table, so every mode decode is seen together with the response it selects.

// File: rtl/int_ctrl_pkg.sv
package int_ctrl_pkg;
  typedef enum logic [1:0] {
    IM_OPC   = 2'd0,
    IM_FIXED = 2'd1,
    IM_VECT  = 2'd2
  } im_e;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_NMI  = 3'd1,
    ACC_IM0  = 3'd2,
    ACC_IM1  = 3'd3,
    ACC_IM2  = 3'd4
  } acc_e;

  // y[1:0]: 0x -> opcode injection, 10 -> fixed restart, 11 -> vectored
  function automatic im_e decode_mode(input logic [2:0] y);
    case (y[1:0])
      2'b10:   return IM_FIXED;
      2'b11:   return IM_VECT;
      default: return IM_OPC;
    endcase
  endfunction
endpackage

// File: rtl/int_nmi_edge.sv
module int_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  output logic rise_o
);
  logic nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nmi_q <= 1'b0;
    else         nmi_q <= nmi_i;
  end

  assign rise_o = nmi_i & ~nmi_q;
endmodule

// File: rtl/int_arbiter.sv
module int_arbiter
  import int_ctrl_pkg::*;
(
  input  logic nmi_rise_i,
  input  logic irq_i,
  input  logic iff1_i,
  input  im_e  mode_i,
  output acc_e kind_o
);
  always_comb begin
    kind_o = ACC_NONE;
    if (nmi_rise_i) begin
      kind_o = ACC_NMI;
    end else if (irq_i && iff1_i) begin
      case (mode_i)
        IM_FIXED: kind_o = ACC_IM1;
        IM_VECT:  kind_o = ACC_IM2;
        default:  kind_o = ACC_IM0;
      endcase
    end
  end
endmodule

// File: rtl/int_state_regs.sv
module int_state_regs
  import int_ctrl_pkg::*;
#(
  parameter int unsigned          DATA_W  = 8,
  parameter logic [DATA_W-1:0]    VEC_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              kind_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              retn_i,
  input  logic              mode_set_i,
  input  logic [2:0]        mode_y_i,
  input  logic              vec_wr_i,
  input  logic [DATA_W-1:0] vec_data_i,
  output logic              iff1_o,
  output logic              iff2_o,
  output im_e               mode_o,
  output logic [DATA_W-1:0] vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iff1_o <= 1'b0;
      iff2_o <= 1'b0;
    end else if (kind_i == ACC_NMI) begin
      iff1_o <= 1'b0;
    end else if (kind_i != ACC_NONE) begin
      iff1_o <= 1'b0;
      iff2_o <= 1'b0;
    end else if (di_i) begin
      iff1_o <= 1'b0;
      iff2_o <= 1'b0;
    end else if (ei_i) begin
      iff1_o <= 1'b1;
      iff2_o <= 1'b1;
    end else if (retn_i) begin
      iff1_o <= iff2_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mode_o <= IM_OPC;
    else if (mode_set_i) mode_o <= decode_mode(mode_y_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       vec_o <= VEC_RST;
    else if (vec_wr_i) vec_o <= vec_data_i;
  end
endmodule

// File: rtl/int_ctrl_unit.sv
module int_ctrl_unit
  import int_ctrl_pkg::*;
#(
  parameter int unsigned           DATA_W       = 8,
  parameter int unsigned           CYC_W        = 5,
  parameter logic [2*DATA_W-1:0]   NMI_TARGET   = 'h0066,
  parameter logic [2*DATA_W-1:0]   FIXED_TARGET = 'h0038,
  parameter int unsigned           NMI_CYCLES   = 13,
  parameter int unsigned           FIXED_CYCLES = 13,
  parameter int unsigned           VECT_CYCLES  = 19,
  parameter logic [DATA_W-1:0]     VEC_RST      = '1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  irq_req_i,
  input  logic                  nmi_req_i,
  input  logic [DATA_W-1:0]     data_i,
  input  logic                  ei_i,
  input  logic                  di_i,
  input  logic                  retn_i,
  input  logic                  mode_set_i,
  input  logic [2:0]            mode_y_i,
  input  logic                  vec_wr_i,
  input  logic [DATA_W-1:0]     vec_data_i,
  output logic                  take_o,
  output logic                  take_nmi_o,
  output logic                  push_pc_o,
  output logic                  exec_opcode_o,
  output logic [DATA_W-1:0]     opcode_o,
  output logic [2*DATA_W-1:0]   target_o,
  output logic [CYC_W-1:0]      cycles_o,
  output logic                  iff1_o,
  output logic                  iff2_o,
  output logic [1:0]            mode_o
);
  localparam int unsigned ADDR_W = 2 * DATA_W;
  localparam logic [CYC_W-1:0] NMI_CYC   = CYC_W'(NMI_CYCLES);
  localparam logic [CYC_W-1:0] FIXED_CYC = CYC_W'(FIXED_CYCLES);
  localparam logic [CYC_W-1:0] VECT_CYC  = CYC_W'(VECT_CYCLES);

  logic              nmi_rise;
  acc_e              kind;
  im_e               mode_q;
  logic [DATA_W-1:0] vec_q;

  int_nmi_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_req_i),
    .rise_o (nmi_rise)
  );

  int_arbiter u_arb (
    .nmi_rise_i (nmi_rise),
    .irq_i      (irq_req_i),
    .iff1_i     (iff1_o),
    .mode_i     (mode_q),
    .kind_o     (kind)
  );

  int_state_regs #(
    .DATA_W  (DATA_W),
    .VEC_RST (VEC_RST)
  ) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (kind),
    .ei_i       (ei_i),
    .di_i       (di_i),
    .retn_i     (retn_i),
    .mode_set_i (mode_set_i),
    .mode_y_i   (mode_y_i),
    .vec_wr_i   (vec_wr_i),
    .vec_data_i (vec_data_i),
    .iff1_o     (iff1_o),
    .iff2_o     (iff2_o),
    .mode_o     (mode_q),
    .vec_o      (vec_q)
  );

  assign mode_o = mode_q;

  // registered one-cycle response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o        <= 1'b0;
      take_nmi_o    <= 1'b0;
      push_pc_o     <= 1'b0;
      exec_opcode_o <= 1'b0;
      opcode_o      <= '0;
      target_o      <= '0;
      cycles_o      <= '0;
    end else begin
      take_o        <= (kind != ACC_NONE);
      take_nmi_o    <= (kind == ACC_NMI);
      push_pc_o     <= (kind == ACC_NMI) || (kind == ACC_IM1) || (kind == ACC_IM2);
      exec_opcode_o <= (kind == ACC_IM0);
      opcode_o      <= (kind == ACC_IM0) ? data_i : '0;
      case (kind)
        ACC_NMI: begin target_o <= NMI_TARGET;      cycles_o <= NMI_CYC;   end
        ACC_IM1: begin target_o <= FIXED_TARGET;    cycles_o <= FIXED_CYC; end
        ACC_IM2: begin target_o <= {vec_q, data_i}; cycles_o <= VECT_CYC;  end
        default: begin target_o <= '0;              cycles_o <= '0;        end
      endcase
    end
  end

  logic unused_addr_w;
  assign unused_addr_w = (ADDR_W == 0);
endmodule

// File: rtl/int_ctrl_unit_chk.sv
module int_ctrl_unit_chk #(
  parameter int unsigned         DATA_W     = 8,
  parameter int unsigned         CYC_W      = 5,
  parameter logic [2*DATA_W-1:0] NMI_TARGET = 'h0066,
  parameter int unsigned         NMI_CYCLES = 13
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                irq_req_i,
  input logic                nmi_rise,
  input logic                ei_i,
  input logic                di_i,
  input logic                take_o,
  input logic                take_nmi_o,
  input logic                push_pc_o,
  input logic                exec_opcode_o,
  input logic [2*DATA_W-1:0] target_o,
  input logic [CYC_W-1:0]    cycles_o,
  input logic                iff1_o,
  input logic                iff2_o
);
  a_r1_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i && !iff1_o && !nmi_rise) |=> !take_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (cycles_o == '0 && !push_pc_o && !exec_opcode_o));

  a_r2_nmi_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_rise |=> (take_o && take_nmi_o));

  a_r3_nmi_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_nmi_o |-> (push_pc_o && target_o == NMI_TARGET
                    && cycles_o == CYC_W'(NMI_CYCLES)));

  a_r3_keep_iff2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_rise |=> (!iff1_o && iff2_o == $past(iff2_o)));

  a_r4_mask_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !take_nmi_o) |-> (!iff1_o && !iff2_o));

  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({push_pc_o, exec_opcode_o}));

  a_r12_di_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (di_i && ei_i) |=> (!iff1_o && !iff2_o));
endmodule

bind int_ctrl_unit int_ctrl_unit_chk #(
  .DATA_W     (DATA_W),
  .CYC_W      (CYC_W),
  .NMI_TARGET (NMI_TARGET),
  .NMI_CYCLES (NMI_CYCLES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_req_i     (irq_req_i),
  .nmi_rise      (nmi_rise),
  .ei_i          (ei_i),
  .di_i          (di_i),
  .take_o        (take_o),
  .take_nmi_o    (take_nmi_o),
  .push_pc_o     (push_pc_o),
  .exec_opcode_o (exec_opcode_o),
  .target_o      (target_o),
  .cycles_o      (cycles_o),
  .iff1_o        (iff1_o),
  .iff2_o        (iff2_o)
);

// File: tb/int_ctrl_unit_test.sv
module int_ctrl_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0, nmi = 1'b0;
  logic [7:0]  data = '0;
  logic        ei = 1'b0, di = 1'b0, retn = 1'b0;
  logic        mset = 1'b0;
  logic [2:0]  my = '0;
  logic        vwr = 1'b0;
  logic [7:0]  vdat = '0;
  logic        take, take_nmi, push, exec;
  logic [7:0]  opcode;
  logic [15:0] target;
  logic [4:0]  cycles;
  logic        iff1, iff2;
  logic [1:0]  mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  int_ctrl_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq), .nmi_req_i(nmi),
    .data_i(data), .ei_i(ei), .di_i(di), .retn_i(retn),
    .mode_set_i(mset), .mode_y_i(my), .vec_wr_i(vwr), .vec_data_i(vdat),
    .take_o(take), .take_nmi_o(take_nmi), .push_pc_o(push),
    .exec_opcode_o(exec), .opcode_o(opcode), .target_o(target),
    .cycles_o(cycles), .iff1_o(iff1), .iff2_o(iff2), .mode_o(mode)
  );

  // y, data, mode, push, exec, target, cycles
  localparam logic [35:0] TBL [8] = '{
    {3'd0, 8'hC7, 2'd0, 1'b0, 1'b1, 16'h0000, 5'd0},
    {3'd1, 8'h3E, 2'd0, 1'b0, 1'b1, 16'h0000, 5'd0},
    {3'd2, 8'h11, 2'd1, 1'b1, 1'b0, 16'h0038, 5'd13},
    {3'd3, 8'h20, 2'd2, 1'b1, 1'b0, 16'hFF20, 5'd19},
    {3'd4, 8'hFF, 2'd0, 1'b0, 1'b1, 16'h0000, 5'd0},
    {3'd5, 8'h00, 2'd0, 1'b0, 1'b1, 16'h0000, 5'd0},
    {3'd6, 8'h55, 2'd1, 1'b1, 1'b0, 16'h0038, 5'd13},
    {3'd7, 8'hFE, 2'd2, 1'b1, 1'b0, 16'hFFFE, 5'd19}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_ei();
    ei = 1'b1; step(); ei = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] y);
    mset = 1'b1; my = y; step(); mset = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R11 reset state
    chk("R11 iff1 reset", iff1, 0);
    chk("R11 iff2 reset", iff2, 0);
    chk("R11 mode reset", mode, 0);
    chk("R1 no take at reset", take, 0);

    // R1 maskable blocked while disabled
    irq = 1'b1; data = 8'h12; step(); irq = 1'b0;
    chk("R1 blocked take", take, 0);
    chk("R1 blocked cycles", cycles, 0);
    chk("R1 blocked push", push, 0);

    // R10 R5 R6 R7 R4: walk every y code
    for (int i = 0; i < 8; i++) begin
      logic [35:0] e;
      e = TBL[i];
      set_mode(e[35:33]);
      chk($sformatf("R10 mode for y=%0d", e[35:33]), mode, e[24:23]);
      pulse_ei();
      chk("R9 ei sets iff1", iff1, 1);
      irq = 1'b1; data = e[32:25]; step(); irq = 1'b0;
      chk("R1 take", take, 1);
      chk("R5 R6 push", push, e[22]);
      chk("R7 exec", exec, e[21]);
      chk("R5 R6 target", target, e[20:5]);
      chk("R5 R6 cycles", cycles, e[4:0]);
      chk("R7 opcode", opcode, e[21] ? e[32:25] : 8'h00);
      chk("R4 iff1 cleared", iff1, 0);
      chk("R4 iff2 cleared", iff2, 0);
      step();
      chk("R1 one-cycle response", take, 0);
    end

    // R11 vector register load used by R6
    vwr = 1'b1; vdat = 8'h12; step(); vwr = 1'b0;
    set_mode(3'd3);
    pulse_ei();
    irq = 1'b1; data = 8'h34; step(); irq = 1'b0;
    chk("R6 loaded vector target", target, 16'h1234);
    chk("R6 loaded vector cycles", cycles, 19);

    // R3 R2 non-maskable with flags set
    pulse_ei();
    nmi = 1'b1; step();
    chk("R3 take_nmi", take_nmi, 1);
    chk("R3 push", push, 1);
    chk("R3 target", target, 16'h0066);
    chk("R3 cycles", cycles, 13);
    chk("R3 iff1 cleared", iff1, 0);
    chk("R3 iff2 kept", iff2, 1);
    repeat (3) begin
      step();
      chk("R2 held level no repeat", take, 0);
    end
    nmi = 1'b0;
    retn = 1'b1; step(); retn = 1'b0;
    chk("R9 retn restores iff1", iff1, 1);

    // R2 non-maskable taken while disabled
    di = 1'b1; step(); di = 1'b0;
    chk("R9 di clears iff1", iff1, 0);
    chk("R9 di clears iff2", iff2, 0);
    nmi = 1'b1; step(); nmi = 1'b0;
    chk("R2 taken while disabled", take_nmi, 1);
    retn = 1'b1; step(); retn = 1'b0;
    chk("R9 retn copies zero", iff1, 0);

    // R8 simultaneous requests
    set_mode(3'd2);
    pulse_ei();
    irq = 1'b1; nmi = 1'b1; step();
    chk("R8 nmi wins", take_nmi, 1);
    chk("R8 nmi target", target, 16'h0066);
    step();
    chk("R8 maskable not taken after", take, 0);
    irq = 1'b0; nmi = 1'b0;
    chk("R8 iff2 kept", iff2, 1);

    // R12 acceptance overrides ei
    pulse_ei();
    irq = 1'b1; ei = 1'b1; data = 8'h00; step(); irq = 1'b0; ei = 1'b0;
    chk("R12 take with ei", take, 1);
    chk("R12 acceptance wins iff1", iff1, 0);
    // R12 di overrides ei
    pulse_ei();
    ei = 1'b1; di = 1'b1; step(); ei = 1'b0; di = 1'b0;
    chk("R12 di over ei", iff1, 0);
    // R12 ei overrides retn
    ei = 1'b1; retn = 1'b1; step(); ei = 1'b0; retn = 1'b0;
    chk("R12 ei over retn iff1", iff1, 1);
    chk("R12 ei over retn iff2", iff2, 1);

    // R11 reset mid-run
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    chk("R11 iff1 after reset", iff1, 0);
    chk("R11 mode after reset", mode, 0);
    set_mode(3'd7);
    pulse_ei();
    irq = 1'b1; data = 8'hAB; step(); irq = 1'b0;
    chk("R11 vector back to FF", target, 16'hFFAB);

    repeat (2) step();
    finish_run();
  end
endmodule